// File: doc/BRIEF.md
# Single-Wire Open-Drain Bus Master

This block drives a single shared open-drain line with an external pull-up. Two operations are supported. The first is a line reset: the master holds the line low, releases it, and then checks whether any attached device answers by pulling the line low. The second is a single-bit write slot: the line is pulled low at the start of a fixed-length slot, and the length of that low pulse carries the bit value. A short released gap follows the slot.

The host starts an operation with a command strobe and waits for the one-cycle `done` pulse. While an operation is running, `busy` is high and any new command is dropped. All durations are counted in microsecond ticks. A divider derives those ticks from the system clock, and its ratio `CLK_PER_US` is a parameter. The line output is a pull-low enable and nothing else, so the block never drives the line high. The line input passes through a two-flop synchronizer before it is used.

Top module: `ow_master`

## Requirements
- R1: After reset, `busy`, `done`, `line_pull` and `presence` are all 0.
- R2: A reset command accepted while idle asserts `line_pull` (1 = pull low) in the first cycle after acceptance and holds it for exactly `RST_LOW_US` microseconds (`RST_LOW_US*CLK_PER_US` cycles), as a single low pulse.
- R3: After that low pulse, the line stays released for `RST_RX_US` microseconds. `busy` is high for `(RST_LOW_US+RST_RX_US)*CLK_PER_US` cycles in total.
- R4: The synchronized line is sampled at the end of microsecond `PRES_SAMPLE_US` of the released window. `presence` becomes 1 if the line was low and 0 if it was high. The flag keeps that value until the next reset's sample, so write slots leave it unchanged.
- R5: A write command accepted while idle pulls the line low from the first cycle. When `wr_bit`=1 the line is released after `W1_LOW_US` microseconds. When `wr_bit`=0 it stays low for the whole `SLOT_US`-microsecond slot.
- R6: Each write slot is followed by `REC_US` microseconds with the line released before `busy` falls. `busy` lasts `(SLOT_US+REC_US)*CLK_PER_US` cycles.
- R7: `done` is high for exactly one cycle: the first cycle after `busy` falls.
- R8: Commands that arrive while `busy` is high are ignored. The running operation keeps its length, and no new operation starts afterwards.
- R9: If `cmd_reset` and `cmd_write` are both high in the same idle cycle, the reset runs.
- R10: The line is only ever pulled low or released. `line_pull` is 0 whenever the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| cmd_reset | input | 1 | Start a line reset and presence check |
| cmd_write | input | 1 | Start a one-bit write slot |
| wr_bit | input | 1 | Bit value for the write slot, captured when the command is accepted |
| busy | output | 1 | An operation is in progress |
| done | output | 1 | One-cycle pulse when an operation ends |
| presence | output | 1 | Result of the most recent presence sample |
| line_pull | output | 1 | Open-drain enable; 1 pulls the line low |
| line_in | input | 1 | Raw level of the shared line |

## Verification
The assertions assume that `rst_n` is released synchronously and that commands are only acted on in idle cycles, so a command held high while `busy` can never restart an operation. They also assume that `line_in` may change at any time but is only read after the synchronizer. The bench changes all inputs on falling clock edges and keeps each command high for a single cycle. It models the device as a pull-low that starts a set number of microseconds after the reset pulse is released, and it uses windows that straddle the sample point as well as windows that miss it.

// File: rtl/ow_pkg.sv
package ow_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RST_LOW,
    ST_RST_RX,
    ST_SLOT,
    ST_REC
  } ow_state_e;
endpackage

// File: rtl/ow_tick_gen.sv
module ow_tick_gen #(
  parameter int CLK_PER_US = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  output logic tick
);
  localparam int DW = (CLK_PER_US > 1) ? $clog2(CLK_PER_US) : 1;
  localparam logic [DW-1:0] LAST = DW'(CLK_PER_US - 1);

  logic [DW-1:0] div_q;

  assign tick = (div_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        div_q <= '0;
    else if (clr)      div_q <= '0;
    else if (tick)     div_q <= '0;
    else               div_q <= div_q + 1'b1;
  end

  generate
    if (CLK_PER_US > 1) begin : g_spacing
      assert_tick_spacing_R2: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
    end
  endgenerate
endmodule

// File: rtl/ow_sync.sv
module ow_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic raw,
  output logic synced
);
  logic meta_q, sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b1;
      sync_q <= 1'b1;
    end else begin
      meta_q <= raw;
      sync_q <= meta_q;
    end
  end

  assign synced = sync_q;
endmodule

// File: rtl/ow_seq.sv
module ow_seq
  import ow_pkg::*;
#(
  parameter int RST_LOW_US     = 480,
  parameter int RST_RX_US      = 480,
  parameter int PRES_SAMPLE_US = 70,
  parameter int SLOT_US        = 64,
  parameter int W1_LOW_US      = 6,
  parameter int REC_US         = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic line_s,
  input  logic cmd_reset,
  input  logic cmd_write,
  input  logic wr_bit,
  output logic start,
  output logic busy,
  output logic done,
  output logic presence,
  output logic line_pull
);
  localparam int MAX_A = (RST_LOW_US > RST_RX_US) ? RST_LOW_US : RST_RX_US;
  localparam int MAX_B = (SLOT_US > REC_US) ? SLOT_US : REC_US;
  localparam int MAXUS = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int UW    = $clog2(MAXUS + 1);

  ow_state_e      state_q;
  logic [UW-1:0]  us_q;
  logic           bit_q;

  assign busy  = (state_q != ST_IDLE);
  assign start = (state_q == ST_IDLE) && (cmd_reset || cmd_write);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      us_q     <= '0;
      bit_q    <= 1'b1;
      done     <= 1'b0;
      presence <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          us_q <= '0;
          if (cmd_reset) begin
            state_q <= ST_RST_LOW;
          end else if (cmd_write) begin
            state_q <= ST_SLOT;
            bit_q   <= wr_bit;
          end
        end
        ST_RST_LOW: if (tick) begin
          if (us_q == UW'(RST_LOW_US - 1)) begin
            state_q <= ST_RST_RX;
            us_q    <= '0;
          end else us_q <= us_q + 1'b1;
        end
        ST_RST_RX: if (tick) begin
          if (us_q == UW'(PRES_SAMPLE_US - 1)) presence <= ~line_s;
          if (us_q == UW'(RST_RX_US - 1)) begin
            state_q <= ST_IDLE;
            us_q    <= '0;
            done    <= 1'b1;
          end else us_q <= us_q + 1'b1;
        end
        ST_SLOT: if (tick) begin
          if (us_q == UW'(SLOT_US - 1)) begin
            state_q <= ST_REC;
            us_q    <= '0;
          end else us_q <= us_q + 1'b1;
        end
        ST_REC: if (tick) begin
          if (us_q == UW'(REC_US - 1)) begin
            state_q <= ST_IDLE;
            us_q    <= '0;
            done    <= 1'b1;
          end else us_q <= us_q + 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // Open-drain enable: only ever requests a low level.
  always_comb begin
    line_pull = 1'b0;
    if (state_q == ST_RST_LOW) line_pull = 1'b1;
    else if (state_q == ST_SLOT)
      line_pull = !bit_q || (us_q < UW'(W1_LOW_US));
  end

  assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_done_after_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));
  assert_no_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RST_RX && cmd_reset) |=> (state_q != ST_RST_LOW));
  assert_idle_released_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !line_pull);
  assert_w1_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SLOT && bit_q && tick && us_q == UW'(W1_LOW_US - 1)) |=> !line_pull);
  assert_presence_sample_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RST_RX && tick && us_q == UW'(PRES_SAMPLE_US - 1))
      |=> (presence == !$past(line_s)));
endmodule

// File: rtl/ow_master.sv
module ow_master #(
  parameter int CLK_PER_US     = 100,
  parameter int RST_LOW_US     = 480,
  parameter int RST_RX_US      = 480,
  parameter int PRES_SAMPLE_US = 70,
  parameter int SLOT_US        = 64,
  parameter int W1_LOW_US      = 6,
  parameter int REC_US         = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cmd_reset,
  input  logic cmd_write,
  input  logic wr_bit,
  output logic busy,
  output logic done,
  output logic presence,
  output logic line_pull,
  input  logic line_in
);
  logic tick, start, line_s;

  ow_tick_gen #(.CLK_PER_US(CLK_PER_US)) u_tick (
    .clk(clk), .rst_n(rst_n), .clr(start), .tick(tick)
  );

  ow_sync u_sync (
    .clk(clk), .rst_n(rst_n), .raw(line_in), .synced(line_s)
  );

  ow_seq #(
    .RST_LOW_US(RST_LOW_US), .RST_RX_US(RST_RX_US),
    .PRES_SAMPLE_US(PRES_SAMPLE_US), .SLOT_US(SLOT_US),
    .W1_LOW_US(W1_LOW_US), .REC_US(REC_US)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .tick(tick), .line_s(line_s),
    .cmd_reset(cmd_reset), .cmd_write(cmd_write), .wr_bit(wr_bit),
    .start(start), .busy(busy), .done(done), .presence(presence),
    .line_pull(line_pull)
  );
endmodule

// File: tb/ow_master_test.sv
module ow_master_test;
  localparam int CPU  = 4;
  localparam int RLOW = 480;
  localparam int RRX  = 480;
  localparam int PSMP = 70;
  localparam int SLOT = 64;
  localparam int W1   = 6;
  localparam int REC  = 2;

  // {is_reset, bit, dev_en, dev_wait_us[7:0], dev_low_us[7:0], exp_presence}
  localparam int NV = 9;
  localparam logic [19:0] VEC [0:NV-1] = '{
    {1'b1, 1'b0, 1'b1, 8'd30,  8'd100, 1'b1},
    {1'b0, 1'b1, 1'b0, 8'd0,   8'd0,   1'b1},
    {1'b0, 1'b0, 1'b0, 8'd0,   8'd0,   1'b1},
    {1'b1, 1'b0, 1'b0, 8'd0,   8'd0,   1'b0},
    {1'b1, 1'b0, 1'b1, 8'd15,  8'd60,  1'b1},
    {1'b1, 1'b0, 1'b1, 8'd60,  8'd240, 1'b1},
    {1'b1, 1'b0, 1'b1, 8'd75,  8'd100, 1'b0},
    {1'b0, 1'b1, 1'b0, 8'd0,   8'd0,   1'b0},
    {1'b0, 1'b0, 1'b0, 8'd0,   8'd0,   1'b0}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_reset = 1'b0, cmd_write = 1'b0, wr_bit = 1'b0;
  logic busy, done, presence, line_pull, line_in;

  logic dev_en = 1'b0;
  int   dev_wait = 0, dev_low = 0;
  int   rel_cnt = 0;
  logic dev_pull;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  ow_master #(
    .CLK_PER_US(CPU), .RST_LOW_US(RLOW), .RST_RX_US(RRX),
    .PRES_SAMPLE_US(PSMP), .SLOT_US(SLOT), .W1_LOW_US(W1), .REC_US(REC)
  ) uut (
    .clk(clk), .rst_n(rst_n), .cmd_reset(cmd_reset), .cmd_write(cmd_write),
    .wr_bit(wr_bit), .busy(busy), .done(done), .presence(presence),
    .line_pull(line_pull), .line_in(line_in)
  );

  // Device model: pulls low for a window measured from the master's release.
  always @(negedge clk) begin
    if (line_pull) rel_cnt <= 0;
    else if (rel_cnt < 100000) rel_cnt <= rel_cnt + 1;
  end
  assign dev_pull = dev_en && (rel_cnt >= dev_wait*CPU) && (rel_cnt < (dev_wait+dev_low)*CPU);
  assign line_in  = ~(line_pull | dev_pull);

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  // Issue one command and measure the operation at the ports.
  task automatic run_op(input bit is_rst, input bit both, input bit b,
                        input bit inject, input int exp_pres, input string tag);
    int cnt, lows, first, last, rises, e_tot, e_low, e_tail;
    bit prev;
    @(negedge clk);
    cmd_reset = is_rst | both;
    cmd_write = !is_rst | both;
    wr_bit = b;
    @(negedge clk);
    cmd_reset = 0; cmd_write = 0;
    cnt = 0; lows = 0; first = 0; last = 0; rises = 0; prev = 0;
    while (busy && cnt < 20000) begin
      cnt++;
      if (line_pull) begin
        lows++;
        last = cnt;
        if (first == 0) first = cnt;
        if (!prev) rises++;
      end
      prev = line_pull;
      if (inject && cnt == 10) begin cmd_reset = 1; cmd_write = 1; wr_bit = 0; end
      if (inject && cnt == 11) begin cmd_reset = 0; cmd_write = 0; end
      @(negedge clk);
    end
    if (is_rst || both) begin
      e_tot = (RLOW+RRX)*CPU; e_low = RLOW*CPU; e_tail = RRX*CPU;
    end else begin
      e_tot  = (SLOT+REC)*CPU;
      e_low  = b ? W1*CPU : SLOT*CPU;
      e_tail = b ? (SLOT-W1+REC)*CPU : REC*CPU;
    end
    chk(cnt == e_tot, {tag, " R3/R6/R8/R9 busy length"}, cnt, e_tot);
    chk(lows == e_low, {tag, " R2/R5 low length"}, lows, e_low);
    chk(first == 1, {tag, " R2/R5 pull starts first cycle"}, first, 1);
    chk(rises == 1, {tag, " R2/R5 single low pulse"}, rises, 1);
    chk(cnt - last == e_tail, {tag, " R3/R6 released tail"}, cnt - last, e_tail);
    chk(done == 1'b1, {tag, " R7 done after busy"}, done, 1);
    chk(line_pull == 1'b0, {tag, " R10 released when idle"}, line_pull, 0);
    @(negedge clk);
    chk(done == 1'b0, {tag, " R7 done single cycle"}, done, 0);
    chk(busy == 1'b0, {tag, " R8 no restart"}, busy, 0);
    chk(presence == exp_pres[0], {tag, " R4 presence"}, presence, exp_pres);
  endtask

  initial begin
    #(150000 * 10);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(busy == 0, "R1 busy", busy, 0);
    chk(done == 0, "R1 done", done, 0);
    chk(line_pull == 0, "R1 line_pull", line_pull, 0);
    chk(presence == 0, "R1 presence", presence, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      dev_en   = VEC[i][17];
      dev_wait = int'(VEC[i][16:9]);
      dev_low  = int'(VEC[i][8:1]);
      run_op(VEC[i][19], 1'b0, VEC[i][18], 1'b0, int'(VEC[i][0]),
             $sformatf("vec%0d", i));
    end

    // R8: commands during a reset are dropped; no device, so presence 0
    dev_en = 0;
    run_op(1'b1, 1'b0, 1'b0, 1'b1, 0, "R8 inject-in-reset");
    // R8: commands during a write-1 slot are dropped
    run_op(1'b0, 1'b0, 1'b1, 1'b1, 0, "R8 inject-in-write");
    // R9: both commands at once -> reset, device answers
    dev_en = 1; dev_wait = 20; dev_low = 120;
    run_op(1'b0, 1'b1, 1'b1, 1'b0, 1, "R9 both-commands");
    dev_en = 0;

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule